// File: doc/BRIEF.md
# Serial Port Modem and Auxiliary Status Registers

This block is the status-register part of a 16550-style serial port that also has an extended operating mode. It takes the four active-low modem control inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) through a two-flop synchronizer. It shows their inverted levels in a modem status byte at offset 6, and it keeps sticky change flags in the same byte. A read of offset 6 clears those flags. While any change flag is set, a modem-status interrupt request is raised.

Offset 7 has two uses. In normal mode it is an 8-bit scratch register that software may read and write freely. In extended mode the same offset reads and writes an auxiliary status register instead. That register holds a receive-FIFO timeout flag and four general bits. It is cleared whenever the mode changes. Transmitter and receiver soft-reset pulses each clear their own bits. The FIFOs, baud generator and serializers sit outside this block; it only receives their timeout and FIFO-read event pulses.

Top module: `uart_stat_regs`

## Requirements
- R1: After reset the modem status change flags (bits 3..0), the auxiliary register, the scratch register and `msi_irq` are all 0. With all modem pins high, offset 6 reads 0x00 and offset 7 reads 0x00 in both modes.
- R2: Bits 4,5,6,7 of offset 6 read the inverse of `cts_n`, `dsr_n`, `ri_n`, `dcd_n` respectively. They follow a pin change two clock edges after it.
- R3: Bit 0 (`cts_n`), bit 1 (`dsr_n`) and bit 3 (`dcd_n`) of offset 6 are set on every change of the matching pin, in either direction. The flag is visible three clock edges after the pin change.
- R4: Bit 2 of offset 6 is set only when `ri_n` goes from 0 to 1. A 1-to-0 change of `ri_n` leaves it at 0.
- R5: A read of offset 6 returns the current value and clears bits 3..0 at that clock edge. If a new change is detected at the same edge, that flag stays set.
- R6: `msi_irq` is 1 exactly while any of bits 3..0 of offset 6 is 1.
- R7: With `ext_mode` = 0, offset 7 is a read/write scratch byte with no side effects.
- R8: With `ext_mode` = 1, offset 7 accesses the auxiliary register. A write updates only bits 2,4,5,6. Bits 1,3,7 read 0. Bit 0 cannot be written.
- R9: Auxiliary bit 0 is set by an `rxf_timeout` pulse and cleared by an `rxf_read` pulse. If both arrive in the same cycle, set wins.
- R10: Any change of `ext_mode` clears the auxiliary register at the next edge. The scratch byte keeps its value across mode changes.
- R11: A `tx_soft_rst` pulse clears auxiliary bits 2 and 6. An `rx_soft_rst` pulse clears auxiliary bits 0, 4 and 5. Both take priority over a write or a timeout in the same cycle.
- R12: Offsets other than 6 and 7 read 0x00. Writes to offset 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| ext_mode | input | 1 | 1 selects extended mode for offset 7 |
| tx_soft_rst | input | 1 | Transmitter soft-reset pulse |
| rx_soft_rst | input | 1 | Receiver soft-reset pulse |
| rxf_timeout | input | 1 | Receive-FIFO timeout event pulse |
| rxf_read | input | 1 | Character-read-from-receive-FIFO pulse |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
After a modem pin changes, the inverted level in bits 7..4 is due two rising edges later. The change flags and `msi_irq` are due three edges later. Offset-7 effects and the clearing by a read appear one edge after the strobe. The bench changes pins just after a falling edge and reads only after the due count of falling edges. For the read/change collision case, it places the read strobe over exactly the edge at which the new flag is registered. All sampling happens one nanosecond after a falling edge, half a period away from any active edge.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int NUM_MODEM  = 4;
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] MSR_OFS = 3'd6;
    localparam logic [ADDR_W-1:0] AUX_OFS = 3'd7;

    // auxiliary register bit groups
    localparam logic [DATA_W-1:0] AUX_WR_MASK = 8'h74; // bits 2,4,5,6
    localparam logic [DATA_W-1:0] AUX_TX_CLR  = 8'h44; // bits 2,6
    localparam logic [DATA_W-1:0] AUX_RX_CLR  = 8'h33; // bits 0,1,4,5
    localparam int                AUX_TOUT_B  = 0;

    // modem pin index inside the 4-bit vectors
    localparam int PIN_CTS = 0;
    localparam int PIN_DSR = 1;
    localparam int PIN_RI  = 2;
    localparam int PIN_DCD = 3;

    typedef struct packed {
        logic [NUM_MODEM-1:0] prev;
        logic [NUM_MODEM-1:0] flags;
    } delta_st_t;

    typedef struct packed {
        logic              ext;
        logic [DATA_W-1:0] aux;
        logic [DATA_W-1:0] scr;
    } aux_st_t;
endpackage

// File: rtl/uart_msr_sync.sv
module uart_msr_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_n_i,
    output logic [WIDTH-1:0] lvl_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_n_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_msr_delta.sv
module uart_msr_delta
    import uart_stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_MODEM-1:0] lvl_i,
    input  logic                 rd_clr_i,
    output logic [NUM_MODEM-1:0] flags_o,
    output logic                 irq_o
);
    delta_st_t            st_d, st_q;
    logic [NUM_MODEM-1:0] chg;
    logic [NUM_MODEM-1:0] set_ev;

    always_comb begin
        chg = lvl_i ^ st_q.prev;
        set_ev          = chg;
        set_ev[PIN_RI]  = lvl_i[PIN_RI] & ~st_q.prev[PIN_RI];
        st_d.prev  = lvl_i;
        st_d.flags = (rd_clr_i ? '0 : st_q.flags) | set_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev  <= '1;
            st_q.flags <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign irq_o   = |st_q.flags;

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && set_ev == '0) |=> st_q.flags == '0);

    a_r5_event_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev != '0) |=> ((st_q.flags & $past(set_ev)) == $past(set_ev)));

    a_r4_teri_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flags[PIN_RI]) |-> $past(lvl_i[PIN_RI] && !st_q.prev[PIN_RI]));

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && st_q.flags[PIN_CTS]) |=> st_q.flags[PIN_CTS]);
endmodule

// File: rtl/uart_aux_scr.sv
module uart_aux_scr
    import uart_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              tx_srst_i,
    input  logic              rx_srst_i,
    input  logic              tout_i,
    input  logic              fifo_rd_i,
    output logic [DATA_W-1:0] aux_o,
    output logic [DATA_W-1:0] scr_o
);
    aux_st_t           st_d, st_q;
    logic [DATA_W-1:0] aux_n;

    always_comb begin
        st_d     = st_q;
        st_d.ext = ext_mode_i;
        if (wr_i && !ext_mode_i) st_d.scr = wdata_i;

        aux_n = st_q.aux;
        if (wr_i && ext_mode_i) aux_n = (aux_n & ~AUX_WR_MASK) | (wdata_i & AUX_WR_MASK);
        if (fifo_rd_i) aux_n[AUX_TOUT_B] = 1'b0;
        if (tout_i)    aux_n[AUX_TOUT_B] = 1'b1;
        if (tx_srst_i) aux_n = aux_n & ~AUX_TX_CLR;
        if (rx_srst_i) aux_n = aux_n & ~AUX_RX_CLR;
        if (ext_mode_i != st_q.ext) aux_n = '0;
        st_d.aux = aux_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ext <= 1'b0;
            st_q.aux <= '0;
            st_q.scr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign aux_o = st_q.aux;
    assign scr_o = st_q.scr;

    a_r10_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode_i != st_q.ext) |=> st_q.aux == '0);

    a_r11_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tx_srst_i |=> (st_q.aux & AUX_TX_CLR) == '0);

    a_r11_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rx_srst_i |=> (st_q.aux & AUX_RX_CLR) == '0);

    a_r7_scratch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && !ext_mode_i) |=> $stable(st_q.scr));

    a_r9_timeout_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_i && !rx_srst_i && ext_mode_i == st_q.ext) |=> st_q.aux[AUX_TOUT_B]);
endmodule

// File: rtl/uart_stat_regs.sv
module uart_stat_regs
    import uart_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    input  logic              ext_mode,
    input  logic              tx_soft_rst,
    input  logic              rx_soft_rst,
    input  logic              rxf_timeout,
    input  logic              rxf_read,
    output logic              msi_irq
);
    logic [NUM_MODEM-1:0] pins_n;
    logic [NUM_MODEM-1:0] lvl;
    logic [NUM_MODEM-1:0] flags;
    logic [DATA_W-1:0]    aux, scr, msr;
    logic                 rd_msr, wr_ofs7;

    always_comb begin
        pins_n          = '1;
        pins_n[PIN_CTS] = cts_n;
        pins_n[PIN_DSR] = dsr_n;
        pins_n[PIN_RI]  = ri_n;
        pins_n[PIN_DCD] = dcd_n;
    end

    assign rd_msr  = rd_en && (addr == MSR_OFS);
    assign wr_ofs7 = wr_en && (addr == AUX_OFS);

    uart_msr_sync #(.WIDTH(NUM_MODEM), .STAGES(SYNC_DEPTH)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (pins_n),
        .lvl_o   (lvl)
    );

    uart_msr_delta delta_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl),
        .rd_clr_i (rd_msr),
        .flags_o  (flags),
        .irq_o    (msi_irq)
    );

    uart_aux_scr aux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_mode_i (ext_mode),
        .wr_i       (wr_ofs7),
        .wdata_i    (wdata),
        .tx_srst_i  (tx_soft_rst),
        .rx_srst_i  (rx_soft_rst),
        .tout_i     (rxf_timeout),
        .fifo_rd_i  (rxf_read),
        .aux_o      (aux),
        .scr_o      (scr)
    );

    assign msr = {~lvl, flags};

    always_comb begin
        case (addr)
            MSR_OFS: rdata = msr;
            AUX_OFS: rdata = ext_mode ? aux : scr;
            default: rdata = '0;
        endcase
    end

    a_r6_irq_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_msr && msr[NUM_MODEM-1:0] != '0) |=> msi_irq);

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |-> (aux & ~(AUX_WR_MASK | (8'h1 << AUX_TOUT_B))) == '0);
endmodule

// File: tb/uart_stat_regs_tb.sv
module uart_stat_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       ext_mode = 1'b0, tx_soft_rst = 1'b0, rx_soft_rst = 1'b0;
    logic       rxf_timeout = 1'b0, rxf_read = 1'b0;
    logic       msi_irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] got;

    always #5 clk = ~clk;

    uart_stat_regs dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
        .dcd_n(dcd_n), .ext_mode(ext_mode), .tx_soft_rst(tx_soft_rst),
        .rx_soft_rst(rx_soft_rst), .rxf_timeout(rxf_timeout), .rxf_read(rxf_read),
        .msi_irq(msi_irq)
    );

    // {dcd_n, ri_n, dsr_n, cts_n} and the offset-6 value expected 3 edges later
    localparam logic [11:0] VEC [8] = '{
        {4'hE, 8'h11}, {4'hC, 8'h32}, {4'h8, 8'h70}, {4'hC, 8'h34},
        {4'h4, 8'hB8}, {4'hB, 8'h4B}, {4'hF, 8'h04}, {4'hF, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_pins(input logic [3:0] p);
        {dcd_n, ri_n, dsr_n, cts_n} = p;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd6, got); check("R1 msr", got, 8'h00);
        rd(3'd7, got); check("R1 scratch", got, 8'h00);
        check("R1 irq", {7'd0, msi_irq}, 8'h00);
        // R12 other offsets and writes to offset 6
        rd(3'd0, got); check("R12 other offset", got, 8'h00);
        wr(3'd6, 8'hFF); rd(3'd6, got); check("R12 msr write ignored", got, 8'h00);

        // R2 R3 R4 R5 vector walk
        for (int i = 0; i < 8; i++) begin
            set_pins(VEC[i][11:8]);
            settle();
            rd(3'd6, got);
            check("R2/R3/R4/R5 vector", got, VEC[i][7:0]);
        end

        // R2 R3 R6 timing: dsr_n low
        set_pins(4'hD);
        @(negedge clk);
        #1 check("R2 not yet", rdata, 8'h00);
        @(negedge clk);
        #1 check("R2 two edges", rdata, 8'h20);
        check("R6 irq not yet", {7'd0, msi_irq}, 8'h00);
        @(negedge clk);
        #1 check("R3 flag at third edge", rdata, 8'h22);
        check("R6 irq set", {7'd0, msi_irq}, 8'h01);
        rd(3'd6, got);
        #1 check("R6 irq cleared by read", {7'd0, msi_irq}, 8'h00);
        set_pins(4'hF); settle(); rd(3'd6, got);

        // R5 collision: read strobe over the edge that registers the new flag
        set_pins(4'hE);
        repeat (2) @(negedge clk);
        rd(3'd6, got); check("R5 read before flag", got, 8'h10);
        rd(3'd6, got); check("R5 flag kept on collision", got, 8'h11);
        rd(3'd6, got); check("R5 cleared after", got, 8'h10);
        set_pins(4'hF); settle(); rd(3'd6, got);

        // R7 scratch
        wr(3'd7, 8'hA5); rd(3'd7, got); check("R7 scratch", got, 8'hA5);
        // R8 R10 extended mode
        ext_mode = 1'b1; @(negedge clk);
        rd(3'd7, got); check("R10 aux clear on entry", got, 8'h00);
        wr(3'd7, 8'hFF); rd(3'd7, got); check("R8 write mask", got, 8'h74);
        // R9
        rxf_timeout = 1'b1; @(negedge clk); rxf_timeout = 1'b0;
        rd(3'd7, got); check("R9 timeout set", got, 8'h75);
        rxf_read = 1'b1; @(negedge clk); rxf_read = 1'b0;
        rd(3'd7, got); check("R9 fifo read clears", got, 8'h74);
        rxf_timeout = 1'b1; rxf_read = 1'b1; @(negedge clk);
        rxf_timeout = 1'b0; rxf_read = 1'b0;
        rd(3'd7, got); check("R9 set wins", got, 8'h75);
        // R11
        tx_soft_rst = 1'b1; @(negedge clk); tx_soft_rst = 1'b0;
        rd(3'd7, got); check("R11 tx soft reset", got, 8'h31);
        wr(3'd7, 8'hFF); rd(3'd7, got); check("R8 write keeps bit0", got, 8'h75);
        rx_soft_rst = 1'b1; @(negedge clk); rx_soft_rst = 1'b0;
        rd(3'd7, got); check("R11 rx soft reset", got, 8'h44);
        wr(3'd7, 8'h3C); rd(3'd7, got); check("R8 ext write", got, 8'h34);
        // R10 mode changes
        ext_mode = 1'b0; @(negedge clk);
        rd(3'd7, got); check("R10 scratch retained", got, 8'hA5);
        ext_mode = 1'b1; @(negedge clk);
        rd(3'd7, got); check("R10 aux cleared", got, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule